// File: doc/BRIEF.md
# Graphics Command Packet Parser

This block sits at the front of a rasteriser and turns a flat stream of 32-bit words into structured work. Each packet opens with a command word that names the drawing operation and the format of everything after it. The parser decodes that word, collects the optional context words that apply to the whole packet, and then cuts the remaining words into one record per primitive (point, line or triangle). Each record carries its vertex words and any mask, line-width, halfspace, colour and depth words that the command asks for.

Words arrive on a valid/ready stream with an end-of-packet flag. Packet length varies: the colour, depth, xy-mask, line-width, clip and halfspace fields of the command word decide both which context words come first and how many words make up each primitive. Span copy, span read, span write and video packets are recognised but not executed; their payload goes out unchanged on a pass-through port. Unknown opcodes and packets that end too early raise sticky error flags, and the parser always recovers at the next command word.

Top module: `gpkt_parser`

## Requirements
- R1: After reset, `in_ready` is 1 and `rec_valid`, `pass_valid`, `err_opcode` and `err_trunc` are 0.
- R2: The first word of a packet is the command word. The outputs hold its fields from the cycle after it is accepted until the next command word is accepted: opcode = bits 3:0, colour mode = bits 5:4, depth mode = bits 7:6, xy-mask mode = bits 9:8, line-width mode = bits 11:10, clip = bit 19, mesh = bit 21, antialias = bit 23, halfspace = bit 31. Opcodes: 0 points, 1 lines, 2 triangles, 5 span copy, 6 span read, 7 span write, 8 video.
- R3: Context words follow the command word in a fixed order. Each is present only when selected: line width (line-width mode 1), xy mask (xy mode 1), then clip minimum and clip maximum (clip bit), constant colour (colour mode 1), constant depth (depth mode 1). A context output that is not selected reads 0. Mode values 2 and 3 add no context word.
- R4: A primitive record is made of these words in this order, each only when selected: xy mask and xy mask address (xy mode 2), the vertex words (1 for points, 2 for lines, 3 for triangles), line width (line-width mode 2), halfspace word (bit 31), colour words (1 for colour mode 2, 3 for mode 3), depth words (1 for depth mode 2, 3 for mode 3). Record fields that carry no word read 0.
- R5: `rec_valid` rises in the cycle after the last word of a record is accepted. While it is high, `in_ready` is 0 and every record field is stable. In the cycle after `rec_ack` is sampled high, `rec_valid` is 0 and the record fields are 0.
- R6: A primitive packet holds any number of records back to back. An end-of-packet flag on the last word of a record ends the packet, and the next word is a command word.
- R7: For opcodes 5 to 8, every word after the context is presented on `pass_data` with `pass_valid` and `pass_last` in the cycle it is accepted, and no record is produced.
- R8: For an opcode not listed in R2, `err_opcode` is set and the words up to end of packet are accepted and dropped, with no pass-through and no record.
- R9: If end of packet arrives before a context group or a record is complete (including on the command word itself when context words are due), `err_trunc` is set, the partial record is not presented, and the next word is a command word. A primitive packet of only a command word is not an error.
- R10: `err_opcode` and `err_trunc` stay set until the next command word is accepted, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input word |
| in_last | input | 1 | Input word ends the packet |
| in_ready | output | 1 | Parser accepts a word this cycle |
| cmd_opcode | output | 4 | Decoded opcode |
| cmd_color_mode | output | 2 | Colour mode |
| cmd_depth_mode | output | 2 | Depth mode |
| cmd_xy_mode | output | 2 | XY-mask mode |
| cmd_lw_mode | output | 2 | Line-width mode |
| cmd_clip | output | 1 | Clip rectangle enabled |
| cmd_mesh | output | 1 | Mesh flag |
| cmd_aa | output | 1 | Antialiased line flag |
| cmd_hs | output | 1 | Halfspace word per primitive |
| ctx_lw | output | 32 | Per-packet line width |
| ctx_xymask | output | 32 | Per-packet xy mask |
| ctx_clip_min | output | 32 | Clip rectangle minimum |
| ctx_clip_max | output | 32 | Clip rectangle maximum |
| ctx_color | output | 32 | Constant colour |
| ctx_depth | output | 32 | Constant depth |
| rec_valid | output | 1 | Primitive record presented |
| rec_ack | input | 1 | Consumer takes the record |
| rec_xymask | output | 32 | Per-primitive xy mask |
| rec_xyaddr | output | 32 | Per-primitive xy mask address |
| rec_vertex | output | 3x32 | Vertex words, index 0 first |
| rec_lw | output | 32 | Per-primitive line width |
| rec_hs | output | 32 | Halfspace condition word |
| rec_color | output | 3x32 | Colour words |
| rec_depth | output | 3x32 | Depth words |
| pass_valid | output | 1 | Pass-through word valid |
| pass_data | output | 32 | Pass-through word |
| pass_last | output | 1 | Pass-through word ends the packet |
| err_opcode | output | 1 | Unknown opcode seen (sticky) |
| err_trunc | output | 1 | Packet ended early (sticky) |

## Verification
On every cycle the assertions check the record handshake: input stalled while a record is shown, record fields frozen until acknowledged, and release right after the acknowledge. They also check that pass-through and records never overlap, that an opcode error suppresses both, and that the command fields move only when a word is taken. The order and count of context and record words for each mode combination, the zeroing of absent fields, the truncation points and the error clearing all depend on whole packets, so only the bench's packet scenarios can show them.

// File: rtl/gpkt_pkg.sv
package gpkt_pkg;

    localparam int WORD_W = 32;
    localparam int CNT_W  = 2;   // up to three words per field
    localparam int NVTX   = 3;   // vertex / smooth-shading slots

    // context kinds, in stream order
    localparam int CTX_N   = 6;
    localparam int CK_LW   = 0;
    localparam int CK_XY   = 1;
    localparam int CK_CMIN = 2;
    localparam int CK_CMAX = 3;
    localparam int CK_COL  = 4;
    localparam int CK_DEP  = 5;

    // primitive kinds, in stream order
    localparam int PRIM_N  = 7;
    localparam int PK_XY   = 0;
    localparam int PK_XYA  = 1;
    localparam int PK_VTX  = 2;
    localparam int PK_LW   = 3;
    localparam int PK_HS   = 4;
    localparam int PK_COL  = 5;
    localparam int PK_DEP  = 6;

    localparam logic [3:0] OP_POINT = 4'd0;
    localparam logic [3:0] OP_LINE  = 4'd1;
    localparam logic [3:0] OP_TRI   = 4'd2;
    localparam logic [3:0] OP_COPY  = 4'd5;
    localparam logic [3:0] OP_VIDEO = 4'd8;

    typedef struct packed {
        logic       hs;
        logic       aa;
        logic       mesh;
        logic       clip;
        logic [1:0] lw;
        logic [1:0] xy;
        logic [1:0] dep;
        logic [1:0] col;
        logic [3:0] op;
    } cmd_t;

    typedef struct packed {
        logic [WORD_W-1:0]           xymask;
        logic [WORD_W-1:0]           xyaddr;
        logic [NVTX-1:0][WORD_W-1:0] vtx;
        logic [WORD_W-1:0]           lw;
        logic [WORD_W-1:0]           hs;
        logic [NVTX-1:0][WORD_W-1:0] col;
        logic [NVTX-1:0][WORD_W-1:0] dep;
    } rec_t;

    function automatic cmd_t decode_cmd(input logic [WORD_W-1:0] w);
        cmd_t c;
        c.op   = w[3:0];
        c.col  = w[5:4];
        c.dep  = w[7:6];
        c.xy   = w[9:8];
        c.lw   = w[11:10];
        c.clip = w[19];
        c.mesh = w[21];
        c.aa   = w[23];
        c.hs   = w[31];
        return c;
    endfunction

    function automatic logic op_is_prim(input logic [3:0] op);
        return op <= OP_TRI;
    endfunction

    function automatic logic op_is_pass(input logic [3:0] op);
        return (op >= OP_COPY) && (op <= OP_VIDEO);
    endfunction

    function automatic logic [CNT_W-1:0] vtx_count(input logic [3:0] op);
        return CNT_W'(op) + CNT_W'(1);
    endfunction

    // flat shading: one word, smooth: one per vertex
    function automatic logic [CNT_W-1:0] shade_words(input logic [1:0] m);
        return (m == 2'd2) ? CNT_W'(1) : ((m == 2'd3) ? CNT_W'(NVTX) : CNT_W'(0));
    endfunction

endpackage

// File: rtl/gpkt_walker.sv
// Steps through a list of field kinds, each repeated 0..3 times.
module gpkt_walker #(
    parameter int NK   = 6,
    parameter int CW   = 2,
    localparam int KW  = $clog2(NK)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic                 rewind,
    input  logic                 step,
    input  logic [NK-1:0][CW-1:0] cnt_in,
    output logic [KW-1:0]        kind,
    output logic [CW-1:0]        sub,
    output logic                 last,
    output logic                 none_in
);

    logic [NK-1:0][CW-1:0] cnt_q;
    logic [KW:0] first_in, first_q, nxt;

    function automatic logic [KW:0] seek(input logic [NK-1:0][CW-1:0] c,
                                         input logic [KW:0] from);
        logic [KW:0] r;
        r = '0;
        for (int i = NK - 1; i >= 0; i--) begin
            if (i >= int'(from) && c[i] != '0) r = {1'b1, KW'(i)};
        end
        return r;
    endfunction

    always_comb begin
        first_in = seek(cnt_in, '0);
        first_q  = seek(cnt_q, '0);
        nxt      = seek(cnt_q, {1'b0, kind} + 1'b1);
        none_in  = !first_in[KW];
        last     = ((sub + CW'(1)) == cnt_q[kind]) && !nxt[KW];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            kind  <= '0;
            sub   <= '0;
        end else if (load) begin
            cnt_q <= cnt_in;
            kind  <= first_in[KW-1:0];
            sub   <= '0;
        end else if (rewind) begin
            kind  <= first_q[KW-1:0];
            sub   <= '0;
        end else if (step) begin
            if ((sub + CW'(1)) != cnt_q[kind]) begin
                sub <= sub + CW'(1);
            end else begin
                kind <= nxt[KW-1:0];
                sub  <= '0;
            end
        end
    end

endmodule

// File: rtl/gpkt_parser.sv
module gpkt_parser
    import gpkt_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    input  logic [WORD_W-1:0]            in_data,
    input  logic                         in_last,
    output logic                         in_ready,
    output logic [3:0]                   cmd_opcode,
    output logic [1:0]                   cmd_color_mode,
    output logic [1:0]                   cmd_depth_mode,
    output logic [1:0]                   cmd_xy_mode,
    output logic [1:0]                   cmd_lw_mode,
    output logic                         cmd_clip,
    output logic                         cmd_mesh,
    output logic                         cmd_aa,
    output logic                         cmd_hs,
    output logic [WORD_W-1:0]            ctx_lw,
    output logic [WORD_W-1:0]            ctx_xymask,
    output logic [WORD_W-1:0]            ctx_clip_min,
    output logic [WORD_W-1:0]            ctx_clip_max,
    output logic [WORD_W-1:0]            ctx_color,
    output logic [WORD_W-1:0]            ctx_depth,
    output logic                         rec_valid,
    input  logic                         rec_ack,
    output logic [WORD_W-1:0]            rec_xymask,
    output logic [WORD_W-1:0]            rec_xyaddr,
    output logic [NVTX-1:0][WORD_W-1:0]  rec_vertex,
    output logic [WORD_W-1:0]            rec_lw,
    output logic [WORD_W-1:0]            rec_hs,
    output logic [NVTX-1:0][WORD_W-1:0]  rec_color,
    output logic [NVTX-1:0][WORD_W-1:0]  rec_depth,
    output logic                         pass_valid,
    output logic [WORD_W-1:0]            pass_data,
    output logic                         pass_last,
    output logic                         err_opcode,
    output logic                         err_trunc
);

    localparam int CKW = $clog2(CTX_N);
    localparam int PKW = $clog2(PRIM_N);

    typedef enum logic [2:0] {S_CMD, S_CTX, S_PRIM, S_HOLD, S_PASS, S_DROP} state_e;

    state_e state;
    cmd_t   cmd_in, cmd_q;
    rec_t   rec_q;
    logic [CTX_N-1:0][WORD_W-1:0] ctx_q;
    logic   end_q;

    logic acc, cmd_acc, ok_op, prim_op;
    logic [CTX_N-1:0][CNT_W-1:0]  ctx_cnt;
    logic [PRIM_N-1:0][CNT_W-1:0] prim_cnt;

    logic [CKW-1:0]   ctx_kind;
    logic [CNT_W-1:0] unused_ctx_sub;
    logic             ctx_last, ctx_none;
    logic [PKW-1:0]   prim_kind;
    logic [CNT_W-1:0] prim_sub;
    logic             prim_last, unused_prim_none;
    logic             rewind;

    assign in_ready = (state != S_HOLD);
    assign acc      = in_valid && in_ready;
    assign cmd_acc  = acc && (state == S_CMD);
    assign cmd_in   = decode_cmd(in_data);
    assign ok_op    = op_is_prim(cmd_in.op) || op_is_pass(cmd_in.op);
    assign prim_op  = op_is_prim(cmd_q.op);
    assign rewind   = (state == S_HOLD) && rec_ack;

    always_comb begin
        ctx_cnt          = '0;
        ctx_cnt[CK_LW]   = CNT_W'(cmd_in.lw == 2'd1);
        ctx_cnt[CK_XY]   = CNT_W'(cmd_in.xy == 2'd1);
        ctx_cnt[CK_CMIN] = CNT_W'(cmd_in.clip);
        ctx_cnt[CK_CMAX] = CNT_W'(cmd_in.clip);
        ctx_cnt[CK_COL]  = CNT_W'(cmd_in.col == 2'd1);
        ctx_cnt[CK_DEP]  = CNT_W'(cmd_in.dep == 2'd1);
        prim_cnt         = '0;
        prim_cnt[PK_XY]  = CNT_W'(cmd_in.xy == 2'd2);
        prim_cnt[PK_XYA] = CNT_W'(cmd_in.xy == 2'd2);
        prim_cnt[PK_VTX] = op_is_prim(cmd_in.op) ? vtx_count(cmd_in.op) : '0;
        prim_cnt[PK_LW]  = CNT_W'(cmd_in.lw == 2'd2);
        prim_cnt[PK_HS]  = CNT_W'(cmd_in.hs);
        prim_cnt[PK_COL] = shade_words(cmd_in.col);
        prim_cnt[PK_DEP] = shade_words(cmd_in.dep);
    end

    gpkt_walker #(.NK(CTX_N), .CW(CNT_W)) u_ctx_walk (
        .clk(clk), .rst(rst), .load(cmd_acc), .rewind(1'b0),
        .step(acc && state == S_CTX), .cnt_in(ctx_cnt),
        .kind(ctx_kind), .sub(unused_ctx_sub), .last(ctx_last), .none_in(ctx_none)
    );

    gpkt_walker #(.NK(PRIM_N), .CW(CNT_W)) u_prim_walk (
        .clk(clk), .rst(rst), .load(cmd_acc), .rewind(rewind),
        .step(acc && state == S_PRIM), .cnt_in(prim_cnt),
        .kind(prim_kind), .sub(prim_sub), .last(prim_last), .none_in(unused_prim_none)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_CMD;
            cmd_q      <= '0;
            ctx_q      <= '0;
            rec_q      <= '0;
            rec_valid  <= 1'b0;
            end_q      <= 1'b0;
            err_opcode <= 1'b0;
            err_trunc  <= 1'b0;
        end else begin
            unique case (state)
                S_CMD: if (acc) begin
                    cmd_q      <= cmd_in;
                    ctx_q      <= '0;
                    rec_q      <= '0;
                    err_opcode <= !ok_op;
                    err_trunc  <= ok_op && !ctx_none && in_last;
                    if (in_last)       state <= S_CMD;
                    else if (!ok_op)   state <= S_DROP;
                    else if (!ctx_none) state <= S_CTX;
                    else               state <= op_is_prim(cmd_in.op) ? S_PRIM : S_PASS;
                end
                S_CTX: if (acc) begin
                    ctx_q[ctx_kind] <= in_data;
                    if (ctx_last)     state <= in_last ? S_CMD : (prim_op ? S_PRIM : S_PASS);
                    else if (in_last) begin
                        err_trunc <= 1'b1;
                        state     <= S_CMD;
                    end
                end
                S_PRIM: if (acc) begin
                    case (prim_kind)
                        PKW'(PK_XY):  rec_q.xymask        <= in_data;
                        PKW'(PK_XYA): rec_q.xyaddr        <= in_data;
                        PKW'(PK_VTX): rec_q.vtx[prim_sub] <= in_data;
                        PKW'(PK_LW):  rec_q.lw            <= in_data;
                        PKW'(PK_HS):  rec_q.hs            <= in_data;
                        PKW'(PK_COL): rec_q.col[prim_sub] <= in_data;
                        default:      rec_q.dep[prim_sub] <= in_data;
                    endcase
                    if (prim_last) begin
                        rec_valid <= 1'b1;
                        end_q     <= in_last;
                        state     <= S_HOLD;
                    end else if (in_last) begin
                        err_trunc <= 1'b1;
                        state     <= S_CMD;
                    end
                end
                S_HOLD: if (rec_ack) begin
                    rec_valid <= 1'b0;
                    rec_q     <= '0;
                    state     <= end_q ? S_CMD : S_PRIM;
                end
                default: if (acc && in_last) state <= S_CMD;
            endcase
        end
    end

    assign cmd_opcode     = cmd_q.op;
    assign cmd_color_mode = cmd_q.col;
    assign cmd_depth_mode = cmd_q.dep;
    assign cmd_xy_mode    = cmd_q.xy;
    assign cmd_lw_mode    = cmd_q.lw;
    assign cmd_clip       = cmd_q.clip;
    assign cmd_mesh       = cmd_q.mesh;
    assign cmd_aa         = cmd_q.aa;
    assign cmd_hs         = cmd_q.hs;

    assign ctx_lw       = ctx_q[CK_LW];
    assign ctx_xymask   = ctx_q[CK_XY];
    assign ctx_clip_min = ctx_q[CK_CMIN];
    assign ctx_clip_max = ctx_q[CK_CMAX];
    assign ctx_color    = ctx_q[CK_COL];
    assign ctx_depth    = ctx_q[CK_DEP];

    assign rec_xymask = rec_q.xymask;
    assign rec_xyaddr = rec_q.xyaddr;
    assign rec_vertex = rec_q.vtx;
    assign rec_lw     = rec_q.lw;
    assign rec_hs     = rec_q.hs;
    assign rec_color  = rec_q.col;
    assign rec_depth  = rec_q.dep;

    assign pass_valid = (state == S_PASS) && in_valid;
    assign pass_data  = in_data;
    assign pass_last  = in_last;

endmodule

// File: rtl/gpkt_parser_chk.sv
module gpkt_parser_chk
    import gpkt_pkg::*;
(
    input logic                        clk,
    input logic                        rst,
    input logic                        in_valid,
    input logic                        in_ready,
    input logic                        in_last,
    input logic                        rec_valid,
    input logic                        rec_ack,
    input logic [NVTX-1:0][WORD_W-1:0] rec_vertex,
    input logic [NVTX-1:0][WORD_W-1:0] rec_color,
    input logic [NVTX-1:0][WORD_W-1:0] rec_depth,
    input logic                        pass_valid,
    input logic                        err_opcode,
    input logic [3:0]                  cmd_opcode
);

    // R5: input is stalled while a record is shown
    assert_stall_on_rec_R5: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> !in_ready);

    // R5: an unacknowledged record stays put
    assert_rec_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && !rec_ack) |=> (rec_valid && $stable(rec_vertex)
                                     && $stable(rec_color) && $stable(rec_depth)));

    // R5: acknowledge releases the record
    assert_rec_release_R5: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_ack) |=> !rec_valid);

    // R7: pass-through and records never overlap
    assert_pass_excl_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pass_valid, rec_valid}));

    // R7: pass-through stops once the packet's last word is taken
    assert_pass_end_R7: assert property (@(posedge clk) disable iff (rst)
        (pass_valid && in_ready && in_last) |=> !pass_valid);

    // R8: an unknown opcode produces neither records nor pass-through
    assert_bad_op_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        err_opcode |-> (!rec_valid && !pass_valid));

    // R2: command fields change only when a word is taken
    assert_cmd_stable_R2: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> $stable(cmd_opcode));

endmodule

bind gpkt_parser gpkt_parser_chk u_chk (.*);

// File: tb/gpkt_parser_bench.sv
module gpkt_parser_bench;
    import gpkt_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, in_last = 1'b0, rec_ack = 1'b0;
    logic [31:0] in_data = '0;
    logic in_ready;
    logic [3:0] cmd_opcode;
    logic [1:0] cmd_color_mode, cmd_depth_mode, cmd_xy_mode, cmd_lw_mode;
    logic cmd_clip, cmd_mesh, cmd_aa, cmd_hs;
    logic [31:0] ctx_lw, ctx_xymask, ctx_clip_min, ctx_clip_max, ctx_color, ctx_depth;
    logic rec_valid;
    logic [31:0] rec_xymask, rec_xyaddr, rec_lw, rec_hs;
    logic [2:0][31:0] rec_vertex, rec_color, rec_depth;
    logic pass_valid, pass_last, err_opcode, err_trunc;
    logic [31:0] pass_data;

    int vectors = 0, miscompares = 0;
    int pass_cnt = 0;
    logic [31:0] pass_x = '0;

    always #10 clk = ~clk;   // 50 MHz

    gpkt_parser u_gpkt_parser (.*);

    always @(posedge clk) begin
        if (!rst && pass_valid && in_ready) begin
            pass_cnt <= pass_cnt + 1;
            pass_x   <= pass_x ^ pass_data;
        end
    end

    // command words for the table loop
    localparam int NROW = 10;
    localparam logic [31:0] ROW_CMD [NROW] = '{
        32'h0000_0000,  // points, nothing extra
        32'h0000_0061,  // lines, flat colour, constant depth
        32'h0000_00F2,  // triangles, smooth colour and depth
        32'h8000_0A00,  // points, per-prim xy and lw, halfspace
        32'h0008_0511,  // lines, clip, per-packet lw and xy, constant colour
        32'h00A0_0082,  // triangles, flat depth, mesh, antialias
        32'h0000_0015,  // span copy, constant colour
        32'h0000_0008,  // video
        32'h0000_0106,  // span read, per-packet xy
        32'h0000_0007   // span write
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] d, input logic l);
        in_valid = 1'b1;
        in_data  = d;
        in_last  = l;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic ack();
        rec_ack = 1'b1;
        @(negedge clk);
        rec_ack = 1'b0;
    endtask

    function automatic int mw(input logic [1:0] m);
        return (m == 2'd2) ? 1 : ((m == 2'd3) ? 3 : 0);
    endfunction

    function automatic logic [31:0] pw(input int r, input int i);
        return 32'hA000_0000 | (r << 8) | i;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 in_ready", 32'(in_ready), 1);
        chk("R1 rec_valid", 32'(rec_valid), 0);
        chk("R1 pass_valid", 32'(pass_valid), 0);
        chk("R1 errors", {30'd0, err_opcode, err_trunc}, 0);

        for (int k = 0; k < NROW; k++) begin
            logic [31:0] c;
            int p, nctx, nv, off_v, off_lw, off_hs, off_c, off_d, tot;
            logic [31:0] e_lw, e_xy, e_cmin, e_cmax, e_col, e_dep;
            c = ROW_CMD[k];
            p = 0;
            e_lw = 0; e_xy = 0; e_cmin = 0; e_cmax = 0; e_col = 0; e_dep = 0;
            if (c[11:10] == 2'd1) begin e_lw = 32'hC000_0000 + p; p++; end
            if (c[9:8] == 2'd1)   begin e_xy = 32'hC000_0000 + p; p++; end
            if (c[19]) begin
                e_cmin = 32'hC000_0000 + p; p++;
                e_cmax = 32'hC000_0000 + p; p++;
            end
            if (c[5:4] == 2'd1) begin e_col = 32'hC000_0000 + p; p++; end
            if (c[7:6] == 2'd1) begin e_dep = 32'hC000_0000 + p; p++; end
            nctx = p;

            send(c, 1'b0);
            chk("R2 opcode", 32'(cmd_opcode), 32'(c[3:0]));
            chk("R2 colour/depth/xy/lw modes",
                {24'd0, cmd_lw_mode, cmd_xy_mode, cmd_depth_mode, cmd_color_mode}, 32'(c[11:4]));
            chk("R2 flags", {28'd0, cmd_hs, cmd_aa, cmd_mesh, cmd_clip},
                {28'd0, c[31], c[23], c[21], c[19]});
            for (int i = 0; i < nctx; i++) send(32'hC000_0000 + i, 1'b0);
            chk("R3 ctx_lw", ctx_lw, e_lw);
            chk("R3 ctx_xymask", ctx_xymask, e_xy);
            chk("R3 ctx_clip_min", ctx_clip_min, e_cmin);
            chk("R3 ctx_clip_max", ctx_clip_max, e_cmax);
            chk("R3 ctx_color", ctx_color, e_col);
            chk("R3 ctx_depth", ctx_depth, e_dep);

            if (c[3:0] <= 4'd2) begin
                nv     = int'(c[3:0]) + 1;
                off_v  = (c[9:8] == 2'd2) ? 2 : 0;
                off_lw = off_v + nv;
                off_hs = off_lw + ((c[11:10] == 2'd2) ? 1 : 0);
                off_c  = off_hs + (c[31] ? 1 : 0);
                off_d  = off_c + mw(c[5:4]);
                tot    = off_d + mw(c[7:6]);
                for (int r = 0; r < 2; r++) begin
                    for (int i = 0; i < tot; i++) send(pw(r, i), (r == 1) && (i == tot - 1));
                    chk("R5 rec_valid", 32'(rec_valid), 1);
                    chk("R5 in_ready low", 32'(in_ready), 0);
                    chk("R4 vertex0", rec_vertex[0], pw(r, off_v));
                    chk("R4 last vertex", rec_vertex[nv-1], pw(r, off_v + nv - 1));
                    chk("R4 vertex2", rec_vertex[2], (nv == 3) ? pw(r, off_v + 2) : 0);
                    chk("R4 xymask", rec_xymask, (off_v == 2) ? pw(r, 0) : 0);
                    chk("R4 xyaddr", rec_xyaddr, (off_v == 2) ? pw(r, 1) : 0);
                    chk("R4 lw", rec_lw, (off_hs != off_lw) ? pw(r, off_lw) : 0);
                    chk("R4 hs", rec_hs, c[31] ? pw(r, off_hs) : 0);
                    chk("R4 colour0", rec_color[0], (off_d != off_c) ? pw(r, off_c) : 0);
                    chk("R4 colour2", rec_color[2], (mw(c[5:4]) == 3) ? pw(r, off_c + 2) : 0);
                    chk("R4 depth0", rec_depth[0], (tot != off_d) ? pw(r, off_d) : 0);
                    ack();
                    chk("R5 released", 32'(rec_valid), 0);
                    chk("R5 cleared", rec_vertex[0], 0);
                end
                chk("R6 ready for next packet", 32'(in_ready), 1);
            end else begin
                int base;
                logic [31:0] x0;
                base = pass_cnt;
                x0   = pass_x;
                for (int i = 0; i < 3; i++) send(32'hB000_0000 + i, i == 2);
                chk("R7 pass count", 32'(pass_cnt - base), 3);
                chk("R7 pass data", pass_x ^ x0, 32'hB000_0003);
                chk("R7 no record", 32'(rec_valid), 0);
            end
        end

        // R5 record held without acknowledge
        send(32'h0000_0001, 1'b0);
        send(32'h0000_1111, 1'b0);
        send(32'h0000_2222, 1'b0);
        repeat (5) @(negedge clk);
        chk("R5 held valid", 32'(rec_valid), 1);
        chk("R5 held ready low", 32'(in_ready), 0);
        chk("R5 held vertex0", rec_vertex[0], 32'h0000_1111);
        chk("R5 held vertex1", rec_vertex[1], 32'h0000_2222);
        ack();
        // R6 second record of the same packet, ending it
        send(32'h0000_3333, 1'b0);
        send(32'h0000_4444, 1'b1);
        chk("R6 second record", rec_vertex[1], 32'h0000_4444);
        ack();

        // R9 truncation inside context (clip needs two words)
        send(32'h0008_0000, 1'b0);
        send(32'h0000_0055, 1'b1);
        chk("R9 ctx truncation", 32'(err_trunc), 1);
        // R10 next command clears; packet parses normally
        send(32'h0000_0000, 1'b0);
        chk("R10 trunc cleared", 32'(err_trunc), 0);
        send(32'h0000_0077, 1'b1);
        chk("R9 recovery record", rec_vertex[0], 32'h0000_0077);
        ack();

        // R9 truncation inside a record
        send(32'h0000_0001, 1'b0);
        send(32'h0000_0099, 1'b1);
        chk("R9 record truncation", 32'(err_trunc), 1);
        chk("R9 no partial record", 32'(rec_valid), 0);

        // R9 command word ends while constant depth is due
        send(32'h0000_0040, 1'b1);
        chk("R9 truncated at command", 32'(err_trunc), 1);

        // R9 lone primitive command is fine
        send(32'h0000_0002, 1'b1);
        chk("R9 empty packet no error", 32'(err_trunc), 0);
        chk("R9 empty packet no record", 32'(rec_valid), 0);

        // R8 unknown opcode drops words, R10 sticky
        begin
            int base;
            base = pass_cnt;
            send(32'h0000_0003, 1'b0);
            chk("R8 err_opcode", 32'(err_opcode), 1);
            send(32'h0000_0001, 1'b0);
            send(32'h0000_0002, 1'b1);
            chk("R10 err_opcode sticky", 32'(err_opcode), 1);
            chk("R8 no pass-through", 32'(pass_cnt - base), 0);
            chk("R8 no record", 32'(rec_valid), 0);
        end
        send(32'h0000_0000, 1'b0);
        chk("R10 err_opcode cleared", 32'(err_opcode), 0);
        send(32'h0000_0123, 1'b1);
        chk("R8 recovered record", rec_vertex[0], 32'h0000_0123);
        ack();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule